// File: doc/BRIEF.md
# Single-Cycle Word Load/Store Processor Core

This block is a small processor core that completes one instruction on every clock edge. It holds a program counter, a register file of thirty-two 32-bit registers, an instruction memory and a data memory. Both memories are organised as 32-bit words but are addressed in bytes, so consecutive words sit 4 addresses apart. Arithmetic and logic work on registers only. Data moves between registers and memory through word loads and stores.

A host fills both memories through a backdoor write port, usually while the core is held in reset. It then releases reset and watches the core. A debug port reads any register combinationally. Two sticky status outputs report an illegal instruction (the core halts and the PC freezes) and a misaligned memory access (the access is suppressed and execution continues).

Instruction fields use a fixed layout: opcode in bits 31:26, first source register in 25:21, second source (or immediate destination) in 20:16, R-format destination in 15:11, function code in 5:0, 16-bit immediate in 15:0, and 26-bit jump word target in 25:0.

Top module: `wordcore_top`

## Requirements
- R1: While `rst_n` is low, on every clock edge the PC becomes 0, every register becomes 0, and both `halted` and `misaligned` become 0.
- R2: Register 0 reads as zero on both operand paths and on the debug port, and any write to it is discarded.
- R3: Opcode 0 selects a register-register operation by function code: 0x20 add, 0x22 subtract (first minus second), 0x24 AND, 0x25 OR, 0x2A signed set-less-than (1 or 0). The result goes to the register in bits 15:11.
- R4: Immediate operations write the register in bits 20:16: opcode 0x08 adds the sign-extended immediate, 0x0A is signed set-less-than against the sign-extended immediate, 0x0C ANDs and 0x0D ORs with the zero-extended immediate, and 0x0F loads the immediate into bits 31:16 with zeros below.
- R5: Opcode 0x23 loads a word and 0x2B stores a word. The byte address is the first source register plus the sign-extended immediate, and the word index is the address divided by 4 (modulo the memory depth).
- R6: A load or store whose byte address has either of its two low bits set writes neither memory nor register, sets `misaligned`, and keeps it set until reset. The PC still advances by 4.
- R7: Opcode 0x04 branches when the two source registers are equal, and 0x05 branches when they differ. A taken branch goes to PC+4 plus the sign-extended immediate times 4. An untaken branch goes to PC+4.
- R8: Opcode 0x02 jumps to {PC+4 bits 31:28, target, 00}. Opcode 0x03 does the same and also writes PC+4 into register 31.
- R9: Opcode 0 with function code 0x08 loads the PC from the first source register with its two low bits cleared.
- R10: Any other encoding sets `halted`. From then until reset, the PC holds the address of that instruction and no register or memory is written.
- R11: A backdoor write with `bd_sel` = 0 stores into the instruction memory and with `bd_sel` = 1 into the data memory, at word index `bd_addr`. `dbg_rdata` shows register `dbg_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bd_we | input | 1 | Backdoor write strobe |
| bd_sel | input | 1 | Backdoor target: 0 instruction memory, 1 data memory |
| bd_addr | input | 6 | Backdoor word index |
| bd_wdata | input | 32 | Backdoor write data |
| dbg_idx | input | 5 | Debug register index |
| dbg_rdata | output | 32 | Debug register value |
| pc_out | output | 32 | Address of the current instruction |
| halted | output | 1 | Sticky illegal-instruction halt |
| misaligned | output | 1 | Sticky misaligned-access flag |

## Verification
The bench uses the default depths of 64 words for each memory. With these depths, a 32-word program reaches every instruction class, a call to word 30 and its return, and both data words it touches without any index wrapping. A second program, loaded after a mid-run reset, covers misaligned store and load suppression, a data word placed through the backdoor, and a halt on an undefined function code. This reset also shows that the registers clear while the memories keep their contents.

// File: rtl/wc_pkg.sv
// Shared encodings and control bundle for the single-cycle word core.
// Assumes the fixed 32-bit instruction field layout described in the brief.
package wc_pkg;
    localparam int XW     = 32;
    localparam int NREGS  = 32;
    localparam int RAW    = $clog2(NREGS);
    localparam logic [RAW-1:0] LINK_REG = RAW'(NREGS - 1);

    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_J    = 6'h02;
    localparam logic [5:0] OP_JAL  = 6'h03;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_BNE  = 6'h05;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SLTI = 6'h0A;
    localparam logic [5:0] OP_ANDI = 6'h0C;
    localparam logic [5:0] OP_ORI  = 6'h0D;
    localparam logic [5:0] OP_LUI  = 6'h0F;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;

    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_SLT  = 6'h2A;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_PASSB} alu_op_t;
    typedef enum logic [1:0] {IMM_SEXT, IMM_ZEXT, IMM_UPPER} imm_kind_t;
    typedef enum logic [1:0] {DST_RD, DST_RT, DST_LINK} dst_t;

    typedef struct packed {
        logic      reg_we;
        dst_t      dst;
        alu_op_t   alu;
        logic      use_imm;
        imm_kind_t immk;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      jreg;
        logic      illegal;
    } ctrl_t;
endpackage

// File: rtl/wc_alu.sv
// Combinational ALU for the word core.
// Assumes operands are two's complement; set-less-than compares signed.
module wc_alu
    import wc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_t      op,
    output logic [W-1:0] y
);
    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_SLT:   y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_PASSB: y = b;
            default:   y = a + b;
        endcase
    end
endmodule

// File: rtl/wc_decode.sv
// Instruction decoder: maps opcode and function code to a control bundle.
// Assumes opcode in bits 31:26 and function code in bits 5:0; any unlisted
// encoding raises the illegal flag.
module wc_decode
    import wc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctrl
);
    logic [5:0] op;
    logic [5:0] fn;
    assign op = instr[31:26];
    assign fn = instr[5:0];

    // Build control signals for the current instruction.
    always_comb begin
        ctrl = '{reg_we: 1'b0, dst: DST_RD, alu: ALU_ADD, use_imm: 1'b0,
                 immk: IMM_SEXT, mem_rd: 1'b0, mem_wr: 1'b0, br_eq: 1'b0,
                 br_ne: 1'b0, jump: 1'b0, jreg: 1'b0, illegal: 1'b0};
        case (op)
            OP_REG: begin
                ctrl.reg_we = 1'b1;
                case (fn)
                    FN_ADD: ctrl.alu = ALU_ADD;
                    FN_SUB: ctrl.alu = ALU_SUB;
                    FN_AND: ctrl.alu = ALU_AND;
                    FN_OR:  ctrl.alu = ALU_OR;
                    FN_SLT: ctrl.alu = ALU_SLT;
                    FN_JR:  begin ctrl.reg_we = 1'b0; ctrl.jreg = 1'b1; end
                    default: begin ctrl.reg_we = 1'b0; ctrl.illegal = 1'b1; end
                endcase
            end
            OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; end
            OP_SLTI: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu = ALU_SLT; end
            OP_ANDI: begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu = ALU_AND; ctrl.immk = IMM_ZEXT; end
            OP_ORI:  begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu = ALU_OR;  ctrl.immk = IMM_ZEXT; end
            OP_LUI:  begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.alu = ALU_PASSB; ctrl.immk = IMM_UPPER; end
            OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.dst = DST_RT; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; end
            OP_SW:   begin ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_BNE:  ctrl.br_ne = 1'b1;
            OP_J:    ctrl.jump = 1'b1;
            OP_JAL:  begin ctrl.jump = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = DST_LINK; end
            default: ctrl.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/wc_regfile.sv
// Register file with three asynchronous read ports and one write port.
// Assumes entry 0 is hard zero; writes land on the rising edge and all
// entries clear under synchronous active-low reset.
module wc_regfile #(
    parameter int N = 32,
    parameter int W = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] regs [N];

    // Clear on reset, otherwise write any entry except zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Read ports force entry zero to zero.
    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/wc_wordmem.sv
// Word-wide storage with one synchronous write port and one asynchronous
// read port. Assumes no reset: contents survive a core reset.
module wc_wordmem #(
    parameter int DEPTH = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Store a word on the rising edge.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/wordcore_top.sv
// Single-cycle core: fetch, decode, execute, memory and writeback all
// complete in one clock. Assumes memories are loaded through the backdoor
// port, normally while reset is held; backdoor writes win over core stores.
module wordcore_top
    import wc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int BAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bd_we,
    input  logic           bd_sel,
    input  logic [BAW-1:0] bd_addr,
    input  logic [31:0]    bd_wdata,
    input  logic [RAW-1:0] dbg_idx,
    output logic [31:0]    dbg_rdata,
    output logic [31:0]    pc_out,
    output logic           halted,
    output logic           misaligned
);
    logic [XW-1:0] pc_q, pc_plus4, pc_next;
    logic          halt_q, mis_q;
    logic [31:0]   instr;
    ctrl_t         ctrl;
    logic [XW-1:0] rs_val, rt_val, imm_val, alu_b, alu_y, dm_rdata, wb_data;
    logic [RAW-1:0] rf_wa;
    logic          rf_we, mis_now, commit_ok, dm_core_we, taken;
    logic          dm_we;
    logic [DAW-1:0] dm_waddr;
    logic [XW-1:0] dm_wdata;

    wc_wordmem #(.DEPTH(IMEM_WORDS), .W(32)) u_imem (
        .clk(clk), .we(bd_we && !bd_sel), .waddr(bd_addr[IAW-1:0]), .wdata(bd_wdata),
        .raddr(pc_q[IAW+1:2]), .rdata(instr)
    );

    wc_decode u_dec (.instr(instr), .ctrl(ctrl));

    wc_regfile #(.N(NREGS), .W(XW)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_wa), .wd(wb_data),
        .ra1(instr[25:21]), .ra2(instr[20:16]), .ra3(dbg_idx),
        .rd1(rs_val), .rd2(rt_val), .rd3(dbg_rdata)
    );

    // Form the immediate operand.
    always_comb begin
        unique case (ctrl.immk)
            IMM_ZEXT:  imm_val = {16'h0, instr[15:0]};
            IMM_UPPER: imm_val = {instr[15:0], 16'h0};
            default:   imm_val = {{16{instr[15]}}, instr[15:0]};
        endcase
    end

    assign alu_b = ctrl.use_imm ? imm_val : rt_val;

    wc_alu #(.W(XW)) u_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu), .y(alu_y));

    assign mis_now    = (ctrl.mem_rd || ctrl.mem_wr) && (alu_y[1:0] != 2'b00);
    assign commit_ok  = !halt_q && !ctrl.illegal && !mis_now;
    assign rf_we      = ctrl.reg_we && commit_ok;
    assign dm_core_we = ctrl.mem_wr && commit_ok;

    // Choose the destination register.
    always_comb begin
        unique case (ctrl.dst)
            DST_RT:   rf_wa = instr[20:16];
            DST_LINK: rf_wa = LINK_REG;
            default:  rf_wa = instr[15:11];
        endcase
    end

    // Backdoor data writes take priority over core stores.
    assign dm_we    = (bd_we && bd_sel) || dm_core_we;
    assign dm_waddr = (bd_we && bd_sel) ? bd_addr[DAW-1:0] : alu_y[DAW+1:2];
    assign dm_wdata = (bd_we && bd_sel) ? bd_wdata : rt_val;

    wc_wordmem #(.DEPTH(DMEM_WORDS), .W(XW)) u_dmem (
        .clk(clk), .we(dm_we), .waddr(dm_waddr), .wdata(dm_wdata),
        .raddr(alu_y[DAW+1:2]), .rdata(dm_rdata)
    );

    assign pc_plus4 = pc_q + XW'(4);
    assign wb_data  = ctrl.mem_rd ? dm_rdata : (ctrl.dst == DST_LINK) ? pc_plus4 : alu_y;
    assign taken    = (ctrl.br_eq && rs_val == rt_val) || (ctrl.br_ne && rs_val != rt_val);

    // Select the next fetch address.
    always_comb begin
        if (ctrl.jreg)      pc_next = {rs_val[XW-1:2], 2'b00};
        else if (ctrl.jump) pc_next = {pc_plus4[31:28], instr[25:0], 2'b00};
        else if (taken)     pc_next = pc_plus4 + {{14{instr[15]}}, instr[15:0], 2'b00};
        else                pc_next = pc_plus4;
    end

    // Advance the PC and update the sticky status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            halt_q <= 1'b0;
            mis_q  <= 1'b0;
        end else if (!halt_q) begin
            if (ctrl.illegal) begin
                halt_q <= 1'b1;
            end else begin
                pc_q <= pc_next;
                if (mis_now) mis_q <= 1'b1;
            end
        end
    end

    assign pc_out     = pc_q;
    assign halted     = halt_q;
    assign misaligned = mis_q;
endmodule

// File: rtl/wc_core_checker.sv
// Property checker for the word core, attached by bind below.
// Assumes synchronous active-low reset; all properties are reset-gated.
module wc_core_checker
    import wc_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [RAW-1:0] dbg_idx,
    input logic [31:0]    dbg_rdata,
    input logic [31:0]    pc_out,
    input logic           halted,
    input logic           misaligned,
    input logic           rf_we
);
    a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_idx == '0) |-> (dbg_rdata == '0));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc_out));

    a_r10_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !rf_we);

    a_r6_misaligned_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |=> misaligned);

    a_r9_pc_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_out[1:0] == 2'b00);
endmodule

bind wordcore_top wc_core_checker u_wc_chk (
    .clk(clk), .rst_n(rst_n), .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata),
    .pc_out(pc_out), .halted(halted), .misaligned(misaligned), .rf_we(rf_we)
);

// File: tb/wordcore_top_bench.sv
`timescale 1ns/1ps
module wordcore_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bd_we = 1'b0;
    logic        bd_sel = 1'b0;
    logic [5:0]  bd_addr = '0;
    logic [31:0] bd_wdata = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_rdata, pc_out;
    logic        halted, misaligned;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    wordcore_top u_wordcore_top (
        .clk(clk), .rst_n(rst_n), .bd_we(bd_we), .bd_sel(bd_sel), .bd_addr(bd_addr),
        .bd_wdata(bd_wdata), .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata),
        .pc_out(pc_out), .halted(halted), .misaligned(misaligned)
    );

    // Expected register file after program one: {requirement, register, value}.
    localparam int NEXP = 21;
    localparam logic [40:0] EXP_TAB [NEXP] = '{
        {4'd4, 5'd1,  32'h0000_0005},   // R4 addi
        {4'd4, 5'd2,  32'hFFFF_FFFD},   // R4 sign-extended immediate
        {4'd3, 5'd3,  32'h0000_0002},   // R3 add
        {4'd3, 5'd4,  32'h0000_0008},   // R3 subtract
        {4'd3, 5'd5,  32'h0000_000D},   // R3 or
        {4'd3, 5'd6,  32'h0000_0008},   // R3 and
        {4'd3, 5'd7,  32'h0000_0001},   // R3 signed slt
        {4'd4, 5'd8,  32'h0000_0001},   // R4 slti signed
        {4'd4, 5'd9,  32'h0000_FFF0},   // R4 andi zero-extended
        {4'd4, 5'd10, 32'h1234_8001},   // R4 lui then ori
        {4'd5, 5'd11, 32'h1234_8001},   // R5 store then load
        {4'd4, 5'd12, 32'h0000_0004},   // R4 base register
        {4'd5, 5'd13, 32'h0000_0005},   // R5 base plus offset
        {4'd7, 5'd14, 32'h0000_0007},   // R7 untaken then taken branch
        {4'd7, 5'd15, 32'h0000_0000},   // R7 taken beq skips
        {4'd9, 5'd16, 32'h0000_0021},   // R9 return lands after call
        {4'd2, 5'd17, 32'h0000_0005},   // R2 zero register as operand
        {4'd8, 5'd18, 32'h0000_0000},   // R8 jump skips
        {4'd8, 5'd19, 32'h0000_0030},   // R8 call target runs
        {4'd8, 5'd31, 32'h0000_005C},   // R8 link value
        {4'd2, 5'd0,  32'h0000_0000}    // R2 write to zero discarded
    };

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int tgt);
        return {op, 26'(tgt)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bd_write(input logic sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        bd_we = 1'b1; bd_sel = sel; bd_addr = 6'(addr); bd_wdata = data;
        @(negedge clk);
        bd_we = 1'b0;
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        @(negedge clk);
        dbg_idx = 5'(idx);
        #1 val = dbg_rdata;
    endtask

    task automatic run_to_halt(input string req);
        int cnt = 0;
        while (!halted && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
        check(req, 32'(halted), 32'd1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] prog [32];
        logic [31:0] v;

        for (int i = 0; i < 32; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'h08, 0, 1, 16'd5);
        prog[1]  = enc_i(6'h08, 0, 2, 16'hFFFD);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 4, 5, 6'h25);
        prog[5]  = enc_r(2, 4, 6, 6'h24);
        prog[6]  = enc_r(2, 1, 7, 6'h2A);
        prog[7]  = enc_i(6'h0A, 2, 8, 16'hFFFE);
        prog[8]  = enc_i(6'h0C, 2, 9, 16'hFFF0);
        prog[9]  = enc_i(6'h0F, 0, 10, 16'h1234);
        prog[10] = enc_i(6'h0D, 10, 10, 16'h8001);
        prog[11] = enc_i(6'h2B, 0, 10, 16'd8);
        prog[12] = enc_i(6'h23, 0, 11, 16'd8);
        prog[13] = enc_i(6'h08, 0, 12, 16'd4);
        prog[14] = enc_i(6'h2B, 12, 1, 16'd12);
        prog[15] = enc_i(6'h23, 0, 13, 16'd16);
        prog[16] = enc_i(6'h04, 1, 3, 16'd1);
        prog[17] = enc_i(6'h08, 0, 14, 16'd7);
        prog[18] = enc_i(6'h05, 1, 3, 16'd1);
        prog[19] = enc_i(6'h08, 0, 14, 16'd99);
        prog[20] = enc_i(6'h04, 1, 1, 16'd1);
        prog[21] = enc_i(6'h08, 0, 15, 16'd99);
        prog[22] = enc_j(6'h03, 30);
        prog[23] = enc_i(6'h08, 0, 16, 16'h21);
        prog[24] = enc_i(6'h08, 0, 0, 16'd9);
        prog[25] = enc_r(0, 1, 17, 6'h20);
        prog[26] = enc_j(6'h02, 28);
        prog[27] = enc_i(6'h08, 0, 18, 16'd99);
        prog[28] = 32'hFC00_0000;
        prog[30] = enc_i(6'h08, 0, 19, 16'h30);
        prog[31] = enc_r(31, 0, 0, 6'h08);

        // R11: load the program through the backdoor during reset.
        for (int i = 0; i < 32; i++) bd_write(1'b0, i, prog[i]);
        @(negedge clk);
        check("R1 pc in reset", pc_out, 32'h0);
        check("R1 halted in reset", 32'(halted), 32'h0);
        check("R1 misaligned in reset", 32'(misaligned), 32'h0);
        rst_n = 1'b1;

        run_to_halt("R10 program one halts");
        check("R10 pc held at illegal word", pc_out, 32'd112);
        check("R6 no misaligned in program one", 32'(misaligned), 32'h0);

        // Table walk over the expected register values.
        for (int i = 0; i < NEXP; i++) begin
            read_reg(int'(EXP_TAB[i][36:32]), v);
            check($sformatf("R%0d table entry %0d reg %0d", EXP_TAB[i][40:37], i, EXP_TAB[i][36:32]),
                  v, EXP_TAB[i][31:0]);
        end

        // R10: PC stays frozen and halt stays set for several cycles.
        repeat (5) @(negedge clk);
        check("R10 pc frozen", pc_out, 32'd112);
        check("R10 halt sticky", 32'(halted), 32'h1);

        // R1: reset mid-run clears every register and the status.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 pc cleared", pc_out, 32'h0);
        check("R1 halt cleared", 32'(halted), 32'h0);
        begin
            int nz = 0;
            for (int r = 0; r < 32; r++) begin
                read_reg(r, v);
                if (v != 32'h0) nz++;
            end
            check("R1 registers cleared", 32'(nz), 32'h0);
        end

        // Program two: misaligned accesses, backdoor data, undefined function code.
        bd_write(1'b0, 0, enc_i(6'h08, 0, 1, 16'h55));
        bd_write(1'b0, 1, enc_i(6'h2B, 0, 1, 16'd8));
        bd_write(1'b0, 2, enc_i(6'h08, 0, 2, 16'h77));
        bd_write(1'b0, 3, enc_i(6'h2B, 0, 2, 16'd9));
        bd_write(1'b0, 4, enc_i(6'h23, 0, 3, 16'd10));
        bd_write(1'b0, 5, enc_i(6'h23, 0, 4, 16'd8));
        bd_write(1'b0, 6, enc_i(6'h23, 0, 5, 16'd20));
        bd_write(1'b0, 7, enc_r(1, 2, 6, 6'h01));
        bd_write(1'b1, 5, 32'hCAFE_F00D);
        @(negedge clk);
        check("R1 misaligned cleared", 32'(misaligned), 32'h0);
        rst_n = 1'b1;

        run_to_halt("R10 undefined function code halts");
        check("R10 pc at undefined function", pc_out, 32'd28);
        check("R6 misaligned flag set", 32'(misaligned), 32'h1);
        read_reg(3, v);
        check("R6 misaligned load writes nothing", v, 32'h0);
        read_reg(4, v);
        check("R6 misaligned store left memory intact", v, 32'h55);
        read_reg(2, v);
        check("R4 second program addi", v, 32'h77);
        read_reg(5, v);
        check("R11 backdoor data word loaded", v, 32'hCAFE_F00D);
        read_reg(6, v);
        check("R10 illegal instruction writes nothing", v, 32'h0);
        repeat (3) @(negedge clk);
        check("R6 misaligned sticky", 32'(misaligned), 32'h1);

        finish_run();
    end
endmodule